// File: doc/BRIEF.md
# Absolute Position Serial Transmitter

This block is the position-sensor end of a clocked synchronous serial link. A receiver drives a clock line. The block answers on a single data line with the current absolute position. That position is given as a multiturn count and a single-turn count, and it is sent in Gray code. The incoming serial clock is sampled in the system clock domain. Its falling and rising transitions are found after a two-stage synchronizer. A retriggerable timeout, counted in system clock cycles, keeps a transfer open for as long as falling transitions keep arriving.

The first falling transition out of the idle state captures the Gray-coded position into a frame register. Each rising transition then presents the next bit, most significant first. One extra rising transition after the last bit drives the line low. If clocking goes on after that, the line either restarts the same captured word or stays low, depending on a mode input. Once the timeout runs out, the line returns high and the block is ready for a new capture.

A state machine holds five states. ST_IDLE is the ready state, with the line high. ST_ARMED follows a capture and waits for the first rising transition. ST_SHIFT sends the frame bits. ST_GAP drives the separator zero. ST_HOLD keeps the line low in single-shot mode. The transitions are as follows:
- IDLE→ARMED on a falling transition, which also captures the position.
- ARMED→SHIFT on a rising transition.
- SHIFT→SHIFT on each rising transition while bits remain.
- SHIFT→GAP on the rising transition after the last bit.
- GAP→SHIFT on a rising transition when repeat mode is set.
- GAP→HOLD on a rising transition when repeat mode is clear.
- Any non-idle state→IDLE when the timeout expires.

Top module: `ssi_enc_tx`

## Requirements
- R1: After reset, and in the ready state, `data_out` is 1.
- R2: A falling transition of `ssi_clk_in` in the ready state captures the position. `data_out` stays 1 until the next rising transition.
- R3: The frame is FRAME_W bits wide. The position is B = {mt_pos, st_pos}, and its Gray code is G = B ^ (B >> 1). The frame holds G in bits [MT_BITS+ST_BITS-1+TRAIL : TRAIL], where TRAIL = FRAME_W - MT_FIELD - ST_BITS. All other frame bits are 0. The k-th rising transition (k = 1..FRAME_W) presents frame bit FRAME_W-k on `data_out`.
- R4: Rising transition number FRAME_W+1 drives `data_out` to 0.
- R5: With `repeat_mode` = 1, every further rising transition continues a cycle of FRAME_W+1 transitions. That cycle sends the same captured frame from its MSB, then one 0.
- R6: With `repeat_mode` = 0, `data_out` stays 0 on all rising transitions after FRAME_W+1.
- R7: Changes of `mt_pos` and `st_pos` after the capture do not change the bits sent, including bits sent in repeats.
- R8: Every falling transition reloads the timeout to MONO_CYC cycles. A serial clock period shorter than MONO_CYC system cycles therefore never ends a transfer.
- R9: MONO_CYC system cycles after the last falling transition, `data_out` returns to 1, even in the middle of a frame. The next falling transition captures the position afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ssi_clk_in | input | 1 | Serial clock from the receiver, idle high, asynchronous |
| mt_pos | input | MT_BITS | Multiturn position, natural binary |
| st_pos | input | ST_BITS | Single-turn position, natural binary |
| repeat_mode | input | 1 | 1: resend the word after the separator; 0: hold the line low |
| data_out | output | 1 | Serial data line, idle high |

## Verification
The hardest case to reach from the ports is a serial clock period just under the timeout. Here the retrigger decides, within a few system cycles, whether a transfer survives. The bench runs a full frame with a period of 56 cycles against a 64-cycle timeout. It also aborts a frame partway by parking the clock high, then proves that the next capture takes the new position. Random frames vary the half-period, the mode, the frame length and the positions. The positions change in the middle of each transfer to show that the captured word holds.

// File: rtl/ssi_enc_pkg.sv
package ssi_enc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SHIFT,
        ST_GAP,
        ST_HOLD
    } tx_state_e;
endpackage

// File: rtl/ssi_edge_det.sv
module ssi_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic fall,
    output logic rise
);
    localparam int CW = SYNC_STAGES + 1;

    logic [CW-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[CW-2:0], async_in};
    end

    // chain_q[CW-1] is the previous synchronized value
    assign fall =  chain_q[CW-1] & ~chain_q[CW-2];
    assign rise = ~chain_q[CW-1] &  chain_q[CW-2];
endmodule

// File: rtl/ssi_gray_frame.sv
module ssi_gray_frame #(
    parameter int MT_BITS  = 8,
    parameter int ST_BITS  = 10,
    parameter int MT_FIELD = 12,
    parameter int FRAME_W  = 25
) (
    input  logic [MT_BITS-1:0] mt_pos,
    input  logic [ST_BITS-1:0] st_pos,
    output logic [FRAME_W-1:0] frame
);
    localparam int POS_W    = MT_BITS + ST_BITS;
    localparam int ST_FIELD = FRAME_W - MT_FIELD;
    localparam int TRAIL    = ST_FIELD - ST_BITS;

    logic [POS_W-1:0] bin_pos;
    logic [POS_W-1:0] gray_pos;

    assign bin_pos  = {mt_pos, st_pos};
    assign gray_pos = bin_pos ^ (bin_pos >> 1);
    // leading zeros come from the width cast, trailing zeros from the shift
    assign frame    = FRAME_W'(gray_pos) << TRAIL;
endmodule

// File: rtl/ssi_monoflop.sv
module ssi_monoflop #(
    parameter int MONO_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic active,
    output logic expire
);
    localparam int CW = $clog2(MONO_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (trig)           cnt_q <= CW'(MONO_CYC);
        else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
    end

    assign active = (cnt_q != '0);
    assign expire = (cnt_q == CW'(1)) && !trig;
endmodule

// File: rtl/ssi_enc_tx.sv
module ssi_enc_tx #(
    parameter int MT_BITS     = 8,
    parameter int ST_BITS     = 10,
    parameter int MT_FIELD    = 12,
    parameter int FRAME_W     = 25,
    parameter int MONO_CYC    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ssi_clk_in,
    input  logic [MT_BITS-1:0] mt_pos,
    input  logic [ST_BITS-1:0] st_pos,
    input  logic               repeat_mode,
    output logic               data_out
);
    import ssi_enc_pkg::*;

    localparam int IW = $clog2(FRAME_W);

    tx_state_e        state_q, state_n;
    logic [IW-1:0]    idx_q, idx_n;
    logic [FRAME_W-1:0] frame_q, frame_n, frame_c;
    logic             load;
    logic             ssi_fall, ssi_rise;
    logic             mono_active, mono_expire;
    logic             out_n, data_q;

    ssi_edge_det #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk(clk), .rst_n(rst_n), .async_in(ssi_clk_in),
        .fall(ssi_fall), .rise(ssi_rise)
    );

    ssi_gray_frame #(
        .MT_BITS(MT_BITS), .ST_BITS(ST_BITS),
        .MT_FIELD(MT_FIELD), .FRAME_W(FRAME_W)
    ) frame_i (
        .mt_pos(mt_pos), .st_pos(st_pos), .frame(frame_c)
    );

    ssi_monoflop #(.MONO_CYC(MONO_CYC)) mono_i (
        .clk(clk), .rst_n(rst_n), .trig(ssi_fall),
        .active(mono_active), .expire(mono_expire)
    );

    // next-state logic
    always_comb begin
        state_n = state_q;
        idx_n   = idx_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ssi_fall) begin
                    state_n = ST_ARMED;
                    load    = 1'b1;
                end
            end
            ST_ARMED: begin
                if (mono_expire) state_n = ST_IDLE;
                else if (ssi_rise) begin
                    state_n = ST_SHIFT;
                    idx_n   = IW'(FRAME_W - 1);
                end
            end
            ST_SHIFT: begin
                if (mono_expire) state_n = ST_IDLE;
                else if (ssi_rise) begin
                    if (idx_q == '0) state_n = ST_GAP;
                    else             idx_n   = idx_q - IW'(1);
                end
            end
            ST_GAP: begin
                if (mono_expire) state_n = ST_IDLE;
                else if (ssi_rise) begin
                    if (repeat_mode) begin
                        state_n = ST_SHIFT;
                        idx_n   = IW'(FRAME_W - 1);
                    end else begin
                        state_n = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (mono_expire) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign frame_n = load ? frame_c : frame_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            frame_q <= '0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
            frame_q <= frame_n;
        end
    end

    // output process
    always_comb begin
        unique case (state_n)
            ST_SHIFT:        out_n = frame_n[idx_n];
            ST_GAP, ST_HOLD: out_n = 1'b0;
            default:         out_n = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= 1'b1;
        else        data_q <= out_n;
    end

    assign data_out = data_q;
endmodule

// File: rtl/ssi_enc_tx_chk.sv
module ssi_enc_tx_chk #(
    parameter int FRAME_W = 25
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     data_out,
    input  ssi_enc_pkg::tx_state_e   state_q,
    input  logic                     ssi_fall,
    input  logic                     mono_active,
    input  logic                     mono_expire,
    input  logic [FRAME_W-1:0]       frame_q
);
    import ssi_enc_pkg::*;

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> data_out);                              // R1

    AST_ARMED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |-> data_out);                             // R2

    AST_GAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> !data_out);                              // R4

    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> !data_out);                             // R6

    AST_FRAME_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(frame_q));                      // R7

    AST_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        ssi_fall |=> mono_active);                                       // R8

    AST_BUSY_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> mono_active);                           // R8

    AST_EXPIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mono_expire |=> (state_q == ST_IDLE) && data_out);               // R9
endmodule

bind ssi_enc_tx ssi_enc_tx_chk #(.FRAME_W(FRAME_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .data_out(data_out), .state_q(state_q),
    .ssi_fall(ssi_fall), .mono_active(mono_active),
    .mono_expire(mono_expire), .frame_q(frame_q)
);

// File: tb/ssi_enc_tx_tb.sv
module ssi_enc_tx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MT_BITS  = 8;
    localparam int ST_BITS  = 10;
    localparam int MT_FIELD = 12;
    localparam int FRAME_W  = 25;
    localparam int MONO_CYC = 64;
    localparam int POS_W    = MT_BITS + ST_BITS;
    localparam int TRAIL    = FRAME_W - MT_FIELD - ST_BITS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ssi_clk_in = 1'b1;
    logic [MT_BITS-1:0] mt_pos = '0;
    logic [ST_BITS-1:0] st_pos = '0;
    logic repeat_mode = 1'b1;
    logic data_out;

    int n_checks = 0;
    int n_fail = 0;
    int frame_errs = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssi_enc_tx #(
        .MT_BITS(MT_BITS), .ST_BITS(ST_BITS), .MT_FIELD(MT_FIELD),
        .FRAME_W(FRAME_W), .MONO_CYC(MONO_CYC), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ssi_clk_in(ssi_clk_in),
        .mt_pos(mt_pos), .st_pos(st_pos), .repeat_mode(repeat_mode),
        .data_out(data_out)
    );

    function automatic logic [FRAME_W-1:0] exp_frame(
        input logic [MT_BITS-1:0] m, input logic [ST_BITS-1:0] s);
        logic [POS_W-1:0] b;
        logic [FRAME_W-1:0] f;
        b = {m, s};
        f = '0;
        for (int j = 0; j < POS_W; j++) begin
            f[j + TRAIL] = b[j] ^ ((j == POS_W - 1) ? 1'b0 : b[j + 1]);
        end
        return f;
    endfunction

    // expected line value after rising transition k (1-based)
    function automatic logic exp_bit(input logic [FRAME_W-1:0] f,
                                     input int k, input logic rep);
        int r;
        if (k > FRAME_W + 1) begin
            if (!rep) return 1'b0;
            r = (k - 1) % (FRAME_W + 1) + 1;
        end else begin
            r = k;
        end
        return (r <= FRAME_W) ? f[FRAME_W - r] : 1'b0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            frame_errs++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one transfer of `cycles` serial periods with half-period h
    task automatic transfer(input logic [MT_BITS-1:0] m, input logic [ST_BITS-1:0] s,
                            input int cycles, input logic rep, input int h,
                            input bit finish);
        logic [FRAME_W-1:0] f;
        string tag;
        mt_pos = m;
        st_pos = s;
        repeat_mode = rep;
        f = exp_frame(m, s);
        wait_cyc(2);
        for (int k = 1; k <= cycles; k++) begin
            ssi_clk_in = 1'b0;
            wait_cyc(h);
            if (k == 1) check("R2 armed line high", data_out, 1);
            ssi_clk_in = 1'b1;
            wait_cyc(h);
            if (k == 4) begin
                mt_pos = MT_BITS'($urandom);   // R7: change after capture
                st_pos = ST_BITS'($urandom);
            end
            if (k <= FRAME_W)          tag = "R3 frame bit";
            else if (k == FRAME_W + 1) tag = "R4 terminating zero";
            else if (rep)              tag = "R5 R7 repeated word";
            else                       tag = "R6 held zero";
            check(tag, data_out, exp_bit(f, k, rep));
        end
        if (finish) begin
            wait_cyc(MONO_CYC + 8);
            check("R9 line ready after timeout", data_out, 1);
        end
    endtask

    initial begin
        int seed_val;
        seed_val = $urandom(32'd2024);
        wait_cyc(3);
        check("R1 reset line high", data_out, 1);
        rst_n = 1'b1;
        wait_cyc(3);
        check("R1 idle line high", data_out, 1);

        // directed corners
        transfer('1, '1, FRAME_W + 1, 1'b0, 6, 1'b1);
        transfer('0, ST_BITS'(1), FRAME_W + 1, 1'b0, 5, 1'b1);
        transfer(MT_BITS'(8'hA5), ST_BITS'(10'h2C3), 2 * (FRAME_W + 1) + 3, 1'b1, 6, 1'b1);
        transfer(MT_BITS'(8'h3C), ST_BITS'(10'h155), FRAME_W + 6, 1'b0, 7, 1'b1);

        // abort in mid-frame, then a fresh capture
        transfer(MT_BITS'(8'h0F), ST_BITS'(10'h3F0), 10, 1'b1, 6, 1'b0);
        wait_cyc(MONO_CYC + 8);
        check("R9 mid-frame timeout", data_out, 1);
        transfer(MT_BITS'(8'hC3), ST_BITS'(10'h0AA), FRAME_W + 1, 1'b1, 6, 1'b1);

        // period just below the timeout
        frame_errs = 0;
        transfer(MT_BITS'(8'h96), ST_BITS'(10'h369), FRAME_W + 3, 1'b1, 28, 1'b1);
        check("R8 long period frame intact", frame_errs, 0);

        // random frames
        for (int i = 0; i < 8; i++) begin
            transfer(MT_BITS'($urandom), ST_BITS'($urandom),
                     FRAME_W + 1 + int'($urandom_range(0, 30)),
                     1'($urandom_range(0, 1)), int'($urandom_range(5, 12)), 1'b1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule